// File: doc/BRIEF.md
# Direct-Register Bank Controller with Down-Counting Interrupt Timer

This block sits on the cartridge side of an 8-bit CPU bus that has a 16-bit address. Each register is loaded by a single bus write to its own fixed address. Four registers hold the 8 KB program-window bank numbers. Eight registers hold the 1 KB pattern-window bank numbers. A 2-bit code selects how the nametables are mirrored. A 16-bit timer counts down and raises an interrupt. The block's outputs are all registered. Other logic turns them into memory addresses.

The timer is loaded one byte at a time. A write to the high byte also arms the timer. Once armed, the timer counts down by one on each CPU-cycle enable pulse. When it reaches zero it raises the IRQ line. The line stays high until software writes the disarm register. Mirroring is set through two registers. One register selects a single screen, and the other selects horizontal or vertical arrangement.

Top module: `bankctl_top`

## Requirements
- R1: After a synchronous reset, all program and pattern bank outputs are 0, the mirroring code is 2'b00 (vertical) and IRQ is low.
- R2: A write to 0x4504 through 0x4507 loads program slot addr[1:0] with the data byte. The new value shows on `prg_bank_o[8*s +: 8]` after the next clock edge. The other slots keep their values.
- R3: A write to 0x4510 through 0x4517 loads pattern slot addr[2:0] with the data byte. The new value shows on `chr_bank_o[8*s +: 8]` after the next edge. The other slots keep their values.
- R4: A write to 0x42FE selects single-screen mirroring. The code becomes 2'b11 (second screen) when data bit 4 is 1, and 2'b10 (first screen) when data bit 4 is 0.
- R5: A write to 0x42FF sets the code to 2'b01 (horizontal) when data bit 4 is 1, and to 2'b00 (vertical) when data bit 4 is 0.
- R6: A write to 0x4502 replaces only bits [7:0] of the counter. A write to 0x4503 replaces only bits [15:8] and arms the timer. Neither write decrements the counter in that cycle.
- R7: While the timer is armed, each clock edge with `cpu_tick` high and no timer write lowers a nonzero counter by one. IRQ rises on the edge of the tick that moves the counter from 1 to 0. Arming with a value N therefore fires on the Nth tick. A counter at 0 stays at 0 and does not fire.
- R8: Once IRQ is high it stays high until a write to 0x4501. That write drops IRQ and disarms the timer on the next edge. The counter keeps its value and does not move while the timer is disarmed.
- R9: A write to any other address, including addresses that match only in some bits, changes no output. With `wr_en` low, no register changes except the armed counter and IRQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| addr | input | 16 | Bus address |
| wdata | input | 8 | Bus write data |
| cpu_tick | input | 1 | CPU-cycle enable that clocks the timer |
| prg_bank_o | output | 32 | Four 8 KB program bank numbers, slot s at [8*s +: 8] |
| chr_bank_o | output | 64 | Eight 1 KB pattern bank numbers, slot s at [8*s +: 8] |
| mirror_o | output | 2 | 00 vertical, 01 horizontal, 10 single first, 11 single second |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
The bench checks the cycle on which IRQ fires, every cycle, against a value N it loads. It loads N through separate low- and high-byte writes. A design that decremented on the arming write, or that fired on reaching 1, would raise IRQ one tick early. A design that replaced the whole counter on a low-byte write would miss the 258-tick firing point. The bench disarms the timer in the middle of a count and later re-arms it with only a high-byte write. A design that lost the remaining count, or kept counting while disarmed, fires at the wrong tick. Bus writes to addresses next to each register, and to addresses whose lower bits alias a register, would corrupt a bank or the mirroring code in a decoder that compares too few address bits. A data byte with bit 4 clear and every other bit set catches a design that reads the wrong data bit.

// File: rtl/bankctl_pkg.sv
package bankctl_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 16;
    localparam int PRG_IDX_W = 2;
    localparam int CHR_IDX_W = 3;
    localparam int PRG_SLOTS = 1 << PRG_IDX_W;
    localparam int CHR_SLOTS = 1 << CHR_IDX_W;
    localparam int TMR_W     = 2 * BYTE_W;
    localparam int SCR_BIT   = 4;

    localparam logic [ADDR_W-1:0] A_TMR_OFF = 16'h4501;
    localparam logic [ADDR_W-1:0] A_TMR_LO  = 16'h4502;
    localparam logic [ADDR_W-1:0] A_TMR_HI  = 16'h4503;
    localparam logic [ADDR_W-1:0] A_PRG     = 16'h4504;
    localparam logic [ADDR_W-1:0] A_CHR     = 16'h4510;
    localparam logic [ADDR_W-1:0] A_SCR_ONE = 16'h42FE;
    localparam logic [ADDR_W-1:0] A_SCR_HV  = 16'h42FF;

    typedef enum logic [1:0] {
        SCR_VERT  = 2'b00,
        SCR_HORZ  = 2'b01,
        SCR_ONE_A = 2'b10,
        SCR_ONE_B = 2'b11
    } scr_mode_e;

    typedef struct packed {
        logic                 tmr_off;
        logic                 tmr_lo;
        logic                 tmr_hi;
        logic                 prg_we;
        logic                 chr_we;
        logic                 scr_one;
        logic                 scr_hv;
        logic [PRG_IDX_W-1:0] prg_idx;
        logic [CHR_IDX_W-1:0] chr_idx;
    } bus_cmd_t;

    function automatic bus_cmd_t decode_bus(input logic we, input logic [ADDR_W-1:0] a);
        bus_cmd_t c;
        c         = '0;
        c.tmr_off = we && (a == A_TMR_OFF);
        c.tmr_lo  = we && (a == A_TMR_LO);
        c.tmr_hi  = we && (a == A_TMR_HI);
        c.scr_one = we && (a == A_SCR_ONE);
        c.scr_hv  = we && (a == A_SCR_HV);
        c.prg_we  = we && (a[ADDR_W-1:PRG_IDX_W] == A_PRG[ADDR_W-1:PRG_IDX_W]);
        c.chr_we  = we && (a[ADDR_W-1:CHR_IDX_W] == A_CHR[ADDR_W-1:CHR_IDX_W]);
        c.prg_idx = a[PRG_IDX_W-1:0];
        c.chr_idx = a[CHR_IDX_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/bankctl_decode.sv
module bankctl_decode
    import bankctl_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output bus_cmd_t          cmd
);

    always_comb begin
        cmd = decode_bus(wr_en, addr);
    end

endmodule

// File: rtl/bankctl_bank_file.sv
module bankctl_bank_file #(
    parameter int SLOTS  = 4,
    parameter int BANK_W = 8,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [IDX_W-1:0]        idx,
    input  logic [BANK_W-1:0]       data,
    output logic [SLOTS*BANK_W-1:0] banks_o
);

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [BANK_W-1:0] bank_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bank_q <= '0;
            end else if (we && (idx == IDX_W'(g))) begin
                bank_q <= data;
            end
        end
        assign banks_o[g*BANK_W +: BANK_W] = bank_q;
    end

    // R2/R3: a slot that is not addressed keeps its value
    p_slot_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(banks_o));

endmodule

// File: rtl/bankctl_mirror.sv
module bankctl_mirror
    import bankctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      one_we,
    input  logic      hv_we,
    input  logic      sel_bit,
    output scr_mode_e mode_o
);

    scr_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= SCR_VERT;
        end else if (one_we) begin
            mode_q <= sel_bit ? SCR_ONE_B : SCR_ONE_A;
        end else if (hv_we) begin
            mode_q <= sel_bit ? SCR_HORZ : SCR_VERT;
        end
    end

    assign mode_o = mode_q;

    // R9: mirroring only moves on one of its two writes
    p_mode_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(one_we || hv_we) |=> $stable(mode_o));

    // R4: a single-screen write always lands in a single-screen code
    p_one_code_r4: assert property (@(posedge clk) disable iff (rst)
        one_we |=> mode_o[1]);

endmodule

// File: rtl/bankctl_irq_timer.sv
module bankctl_irq_timer
    import bankctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              off_we,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [BYTE_W-1:0] data,
    output logic              irq_o
);

    logic [TMR_W-1:0] cnt_q;
    logic             armed_q;
    logic             irq_q;
    logic             step;

    assign step = armed_q && tick && (cnt_q != '0) && !(off_we || lo_we || hi_we);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            if (off_we) begin
                armed_q <= 1'b0;
                irq_q   <= 1'b0;
            end else if (hi_we) begin
                armed_q <= 1'b1;
            end
            if (lo_we) begin
                cnt_q[BYTE_W-1:0] <= data;
            end else if (hi_we) begin
                cnt_q[TMR_W-1:BYTE_W] <= data;
            end else if (step) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == TMR_W'(1)) begin
                    irq_q <= 1'b1;
                end
            end
        end
    end

    assign irq_o = irq_q;

    // R8: the request holds until the disarm write
    p_irq_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !off_we) |=> irq_o);

    // R8: the disarm write drops the request
    p_irq_drop_r8: assert property (@(posedge clk) disable iff (rst)
        off_we |=> !irq_o);

    // R7: the request only rises on a tick that empties the counter
    p_irq_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> ($past(tick) && $past(cnt_q) == TMR_W'(1) && cnt_q == '0));

    // R8: a disarmed counter does not move without a write
    p_cnt_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (!armed_q && !lo_we && !hi_we) |=> $stable(cnt_q));

endmodule

// File: rtl/bankctl_top.sv
module bankctl_top
    import bankctl_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [BYTE_W-1:0]             wdata,
    input  logic                          cpu_tick,
    output logic [PRG_SLOTS*BYTE_W-1:0]   prg_bank_o,
    output logic [CHR_SLOTS*BYTE_W-1:0]   chr_bank_o,
    output logic [1:0]                    mirror_o,
    output logic                          irq_o
);

    bus_cmd_t  cmd;
    scr_mode_e scr_mode;

    bankctl_decode u_dec (
        .wr_en (wr_en),
        .addr  (addr),
        .cmd   (cmd)
    );

    bankctl_bank_file #(.SLOTS(PRG_SLOTS), .BANK_W(BYTE_W)) u_prg (
        .clk     (clk),
        .rst     (rst),
        .we      (cmd.prg_we),
        .idx     (cmd.prg_idx),
        .data    (wdata),
        .banks_o (prg_bank_o)
    );

    bankctl_bank_file #(.SLOTS(CHR_SLOTS), .BANK_W(BYTE_W)) u_chr (
        .clk     (clk),
        .rst     (rst),
        .we      (cmd.chr_we),
        .idx     (cmd.chr_idx),
        .data    (wdata),
        .banks_o (chr_bank_o)
    );

    bankctl_mirror u_mir (
        .clk     (clk),
        .rst     (rst),
        .one_we  (cmd.scr_one),
        .hv_we   (cmd.scr_hv),
        .sel_bit (wdata[SCR_BIT]),
        .mode_o  (scr_mode)
    );

    bankctl_irq_timer u_tmr (
        .clk    (clk),
        .rst    (rst),
        .tick   (cpu_tick),
        .off_we (cmd.tmr_off),
        .lo_we  (cmd.tmr_lo),
        .hi_we  (cmd.tmr_hi),
        .data   (wdata),
        .irq_o  (irq_o)
    );

    assign mirror_o = scr_mode;

    // R9: at most one register is addressed by any write
    p_one_target_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd.tmr_off, cmd.tmr_lo, cmd.tmr_hi, cmd.prg_we,
                  cmd.chr_we, cmd.scr_one, cmd.scr_hv}));

    // R9: no bus write, no bank change
    p_banks_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(prg_bank_o) && $stable(chr_bank_o)));

    // R2: a program write never disturbs the pattern banks
    p_prg_only_r2: assert property (@(posedge clk) disable iff (rst)
        cmd.prg_we |=> $stable(chr_bank_o));

endmodule

// File: tb/sim_bankctl_top.sv
module sim_bankctl_top;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    typedef struct packed {
        logic [31:0] prg;
        logic [63:0] chr;
        logic [1:0]  mir;
        logic        irq;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        cpu_tick = 1'b0;
    logic [31:0] prg_bank_o;
    logic [63:0] chr_bank_o;
    logic [1:0]  mirror_o;
    logic        irq_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    exp_t  q_exp[$];
    string q_tag[$];

    // reference state, built from the requirements
    logic [31:0] m_prg = '0;
    logic [63:0] m_chr = '0;
    logic [1:0]  m_mir = 2'b00;
    logic [15:0] m_cnt = '0;
    logic        m_arm = 1'b0;
    logic        m_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bankctl_top u0 (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .cpu_tick   (cpu_tick),
        .prg_bank_o (prg_bank_o),
        .chr_bank_o (chr_bank_o),
        .mirror_o   (mirror_o),
        .irq_o      (irq_o)
    );

    task automatic push_exp(input string tag);
        exp_t e;
        e.prg = m_prg;
        e.chr = m_chr;
        e.mir = m_mir;
        e.irq = m_irq;
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    task automatic step(input logic w, input logic [15:0] a, input logic [7:0] d,
                        input logic t, input string tag);
        logic tw;
        @(negedge clk);
        wr_en    = w;
        addr     = a;
        wdata    = d;
        cpu_tick = t;
        @(posedge clk);
        tw = w && (a == 16'h4501 || a == 16'h4502 || a == 16'h4503);
        if (w) begin
            if (a >= 16'h4504 && a <= 16'h4507) m_prg[8*a[1:0] +: 8] = d;
            if (a >= 16'h4510 && a <= 16'h4517) m_chr[8*a[2:0] +: 8] = d;
            if (a == 16'h42FE) m_mir = d[4] ? 2'b11 : 2'b10;
            if (a == 16'h42FF) m_mir = d[4] ? 2'b01 : 2'b00;
            if (a == 16'h4501) begin m_arm = 1'b0; m_irq = 1'b0; end
            if (a == 16'h4502) m_cnt[7:0] = d;
            if (a == 16'h4503) begin m_cnt[15:8] = d; m_arm = 1'b1; end
        end
        if (!tw && m_arm && t && m_cnt != 0) begin
            if (m_cnt == 16'd1) m_irq = 1'b1;
            m_cnt = m_cnt - 1'b1;
        end
        push_exp(tag);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
        step(1'b1, a, d, 1'b0, tag);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 16'h0000, 8'h00, 1'b1, tag);
    endtask

    // monitor: compare one expected item per cycle, after the edge
    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            exp_t  e;
            string tg;
            e  = q_exp.pop_front();
            tg = q_tag.pop_front();
            n_checks++;
            if (prg_bank_o !== e.prg || chr_bank_o !== e.chr ||
                mirror_o !== e.mir || irq_o !== e.irq) begin
                n_fails++;
                $display("FAIL %s: got prg=%h chr=%h mir=%b irq=%b, expected prg=%h chr=%h mir=%b irq=%b",
                         tg, prg_bank_o, chr_bank_o, mirror_o, irq_o,
                         e.prg, e.chr, e.mir, e.irq);
            end
        end
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: got no end of run, expected end within %0d cycles", MAX_CYCLES);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step(1'b0, 16'h0000, 8'h00, 1'b0, "R1 reset state");

        // R2: program slots
        wr(16'h4504, 8'h11, "R2 prg slot0");
        wr(16'h4505, 8'h22, "R2 prg slot1");
        wr(16'h4506, 8'h33, "R2 prg slot2");
        wr(16'h4507, 8'hFF, "R2 prg slot3");
        wr(16'h4505, 8'h5A, "R2 prg overwrite slot1");

        // R3: pattern slots
        for (int i = 0; i < 8; i++) wr(16'h4510 + 16'(i), 8'h80 + 8'(i), "R3 chr slot");
        wr(16'h4513, 8'h00, "R3 chr overwrite slot3");

        // R4 and R5: mirroring
        wr(16'h42FE, 8'h00, "R4 single first");
        wr(16'h42FE, 8'h10, "R4 single second");
        wr(16'h42FE, 8'hEF, "R4 bit4 clear others set");
        wr(16'h42FF, 8'h10, "R5 horizontal");
        wr(16'h42FF, 8'h00, "R5 vertical");
        wr(16'h42FF, 8'hEF, "R5 bit4 clear others set");

        // R9: neighbours and aliases change nothing
        wr(16'h4500, 8'hA5, "R9 addr 4500");
        wr(16'h4508, 8'hA5, "R9 addr 4508");
        wr(16'h450F, 8'hA5, "R9 addr 450F");
        wr(16'h4518, 8'hA5, "R9 addr 4518");
        wr(16'h42FD, 8'hA5, "R9 addr 42FD");
        wr(16'hC504, 8'hA5, "R9 alias C504");
        wr(16'h0512, 8'hA5, "R9 alias 0512");
        wr(16'h62FE, 8'h10, "R9 alias 62FE");

        // R6/R7: unarmed ticks do nothing, then fire on the 4th tick
        wr(16'h4502, 8'h04, "R6 load low");
        ticks(3, "R7 unarmed ticks");
        wr(16'h4503, 8'h00, "R6 load high and arm");
        ticks(2, "R7 counting");
        step(1'b0, 16'h0000, 8'h00, 1'b0, "R7 no tick gap");
        ticks(1, "R7 counting");
        ticks(1, "R7 fire on 4th tick");
        ticks(3, "R8 irq sticky");
        wr(16'h4501, 8'h00, "R8 disarm drops irq");

        // R6: low-byte write keeps high byte, 0x0102 ticks
        wr(16'h4503, 8'h01, "R6 arm with high 01");
        wr(16'h4502, 8'h02, "R6 low only");
        ticks(258, "R7 long count");
        ticks(1, "R8 still high");
        wr(16'h4501, 8'h00, "R8 disarm");

        // R8: disarm retains count
        wr(16'h4502, 8'h05, "R6 load low 05");
        wr(16'h4503, 8'h00, "R6 arm");
        ticks(2, "R7 partial count");
        wr(16'h4501, 8'h00, "R8 disarm mid-count");
        ticks(10, "R8 frozen while disarmed");
        wr(16'h4503, 8'h00, "R8 re-arm keeps low byte");
        ticks(3, "R8 fire after remaining count");
        wr(16'h4501, 8'h00, "R8 disarm");

        // R7: zero count never fires
        wr(16'h4502, 8'h00, "R6 low zero");
        wr(16'h4503, 8'h00, "R6 arm zero");
        ticks(5, "R7 zero holds without firing");

        repeat (3) step(1'b0, 16'h0000, 8'h00, 1'b0, "R9 idle");
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule